// File: doc/BRIEF.md
# Dual-Channel Sample Output Port

This block hands finished output samples of a two-channel receiver to the pins. Each time the datapath raises its sample-period strobe, the block captures the 32-bit word of channel A and the 32-bit word of channel B. It then publishes them in two ways at once. The first is a pair of serial data lines that share one bit clock and one frame-sync line. The second is a 16-bit parallel bus whose content is picked by a 3-bit select.

A ready line pulses for one master-clock cycle when each new sample period starts. The polarity of the ready line, the bit clock and the frame sync can each be inverted. The bit clock is either made inside the block by dividing the master clock, or taken from an external pin. In the external case the pin is resynchronised, and each half period of the external clock must last at least two master-clock cycles.

Tri-state control is brought out as enable signals. The serial enable comes from a configuration bit. The parallel enable comes from a pin.

Top module: `chan_out_port`

## Requirements
- R1: During and straight after reset, ser_oe is 0, rdy_out sits at its inactive level (equal to rdy_pol), and par_data is 0.
- R2: ser_oe equals the value ser_en had in the previous clock cycle, so the serial lines are never driven until the enable bit has been written to 1.
- R3: par_oe always equals par_en_pin, independent of every configuration bit.
- R4: par_data is chosen by par_sel as follows:
  - 0 gives A[31:16]
  - 1 gives A[15:0]
  - 2 gives B[31:16]
  - 3 gives B[15:0]
  - 4 gives {A[31:24],B[31:24]}
  - 5 gives {A[23:16],B[23:16]}
  - 6 gives {A[15:8],B[15:8]}
  - 7 gives {A[7:0],B[7:0]}
- R5: The words behind par_data are those present on word_a/word_b at the clock edge where osp_stb was high. Changes on word_a/word_b at any other time do not alter par_data.
- R6: rdy_out is active (rdy_out != rdy_pol) in exactly the one cycle that follows each cycle with osp_stb high.
- R7: With sck_ext_sel=0, the bit clock has a period of 2*(sck_div+1) master-clock cycles, and sck_out is inverted when sck_pol=1.
- R8: With sck_ext_sel=1, sck_out equals sck_in delayed by three master-clock cycles, XOR sck_pol.
- R9: Frame sync (fs_out XOR fs_pol) is active for exactly one bit-clock period. That period ends just before the first data bit of a word and holds no data bit.
- R10: After frame sync, each word is sent MSB first over 32 bit-clock periods: channel A on ser_a and channel B on ser_b. Data changes on the falling edge of the effective bit clock and is stable at its rising edge.
- R11: A sample strobed while a word is still shifting is held. Its frame-sync period follows the last bit of the current word with no idle bit clock between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osp_stb | input | 1 | Start of a new output sample period; captures both words |
| word_a | input | 32 | Formatted channel A word |
| word_b | input | 32 | Formatted channel B word |
| ser_en | input | 1 | Configuration: drive serial outputs |
| rdy_pol | input | 1 | Configuration: invert ready |
| sck_pol | input | 1 | Configuration: invert bit clock |
| fs_pol | input | 1 | Configuration: invert frame sync |
| sck_ext_sel | input | 1 | Configuration: 1 selects the external bit clock |
| sck_div | input | 8 | Configuration: internal bit clock half period minus one |
| sck_in | input | 1 | External bit clock pin |
| par_en_pin | input | 1 | Parallel bus enable pin |
| par_sel | input | 3 | Parallel bus content select |
| ser_a | output | 1 | Channel A serial data |
| ser_b | output | 1 | Channel B serial data |
| ser_oe | output | 1 | Output enable of the serial data, clock and sync lines |
| sck_out | output | 1 | Bit clock |
| fs_out | output | 1 | Frame sync |
| rdy_out | output | 1 | Ready pulse |
| par_data | output | 16 | Parallel bus data |
| par_oe | output | 1 | Parallel bus output enable |

## Verification
The hardest case to reach from the ports is a second strobe landing while a word is still shifting. In that case the held word must begin at the very next bit clock, with no idle gap. The stimulus reaches it by counting decoded bit-clock edges of the first frame and firing a strobe partway through. The receiver model then demands frame sync on the first rising edge after the final data bit.

The external-clock path is also awkward to reach. It is driven by a bench-generated pin clock, and the bench checks the three-cycle resynchronisation delay cycle by cycle. It also decodes whole frames in that mode.

// File: rtl/chan_out_pkg.sv
// Shared definitions for the channel output port.
// Assumes two channels (A at index 0, B at index 1).
package chan_out_pkg;
    localparam int NCH = 2;

    typedef enum logic [1:0] {
        SER_IDLE = 2'd0,
        SER_SYNC = 2'd1,
        SER_DATA = 2'd2
    } ser_state_e;
endpackage

// File: rtl/out_sck_gen.sv
// Bit clock source. It either divides the master clock (half period = div+1
// cycles) or resynchronises an external clock pin. It produces the effective
// raw clock and a one-cycle tick that is high on the cycle whose closing edge
// makes the raw clock fall.
// Assumes an external clock half period of at least two master cycles.
module out_sck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             use_ext,
    input  logic [DIV_W-1:0] div,
    input  logic             ext_sck,
    output logic             sck_raw,
    output logic             bit_tick
);
    logic [DIV_W-1:0] cnt;
    logic             sck_int;
    logic             sync1, sync2, sck_d;

    // Internal divider: toggle the clock every div+1 master cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            sck_int <= 1'b0;
        end else if (cnt == div) begin
            cnt     <= '0;
            sck_int <= ~sck_int;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // External pin: two-flop synchroniser plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            sck_d <= 1'b0;
        end else begin
            sync1 <= ext_sck;
            sync2 <= sync1;
            sck_d <= sync2;
        end
    end

    // Select the source; the tick lines up with the coming falling edge.
    always_comb begin
        if (use_ext) begin
            sck_raw  = sck_d;
            bit_tick = sck_d & ~sync2;
        end else begin
            sck_raw  = sck_int;
            bit_tick = sck_int && (cnt == div);
        end
    end
endmodule

// File: rtl/out_par_mux.sv
// Captures both channel words at each sample strobe and picks a 16-bit
// view of them for the parallel bus. The captured words also feed the
// serial shifter, so one storage set serves both outputs.
// Assumes WORD_W == 2*PAR_W.
module out_par_mux
    import chan_out_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int PAR_W  = 16,
    parameter int SEL_W  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          stb,
    input  logic [WORD_W-1:0]             word_a,
    input  logic [WORD_W-1:0]             word_b,
    input  logic [SEL_W-1:0]              sel,
    output logic [NCH-1:0][WORD_W-1:0]    lat_words,
    output logic [PAR_W-1:0]              par_data
);
    localparam int BYTE_W = PAR_W / 2;

    // Word capture on the sample-period strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_words <= '0;
        end else if (stb) begin
            lat_words[0] <= word_a;
            lat_words[1] <= word_b;
        end
    end

    // Slice select: upper codes interleave one byte of each channel.
    always_comb begin
        logic [WORD_W-1:0] w;
        int                hi;
        w  = lat_words[sel[1]];
        hi = (WORD_W - 1) - int'(sel[1:0]) * BYTE_W;
        if (!sel[SEL_W-1]) begin
            par_data = sel[0] ? w[PAR_W-1:0] : w[WORD_W-1 -: PAR_W];
        end else begin
            par_data = {lat_words[0][hi -: BYTE_W], lat_words[1][hi -: BYTE_W]};
        end
    end
endmodule

// File: rtl/out_ser_shift.sv
// Serial word engine shared by both channels. It holds one pending sample.
// On a bit tick it sends one frame-sync period, then WORD_W data bits
// MSB first. A sample that is pending at the final bit starts at once.
// Assumes `words` is stable except at strobe edges.
module out_ser_shift
    import chan_out_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bit_tick,
    input  logic                       stb,
    input  logic [NCH-1:0][WORD_W-1:0] words,
    output logic [NCH-1:0]             ser_bits,
    output logic                       fs_raw
);
    localparam int CNT_W = $clog2(WORD_W);

    ser_state_e        state;
    logic [CNT_W-1:0]  bitcnt;
    logic              pend;
    logic              last_bit;
    logic              load;

    assign last_bit = (state == SER_DATA) && (bitcnt == '0);
    assign load     = bit_tick && pend && ((state == SER_IDLE) || last_bit);
    assign fs_raw   = (state == SER_SYNC);

    // Pending flag: set by a strobe, cleared when the word is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= (pend && !load) || stb;
    end

    // Frame sequencing on bit ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SER_IDLE;
            bitcnt <= '0;
        end else if (bit_tick) begin
            unique case (state)
                SER_IDLE: if (pend) state <= SER_SYNC;
                SER_SYNC: begin
                    state  <= SER_DATA;
                    bitcnt <= CNT_W'(WORD_W - 1);
                end
                SER_DATA: begin
                    if (bitcnt == '0) state <= pend ? SER_SYNC : SER_IDLE;
                    else              bitcnt <= bitcnt - 1'b1;
                end
                default: state <= SER_IDLE;
            endcase
        end
    end

    // One shift register per channel.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [WORD_W-1:0] sh;

        // Load at frame start, shift left after each sent bit.
        always_ff @(posedge clk) begin
            if (!rst_n)                                          sh <= '0;
            else if (load)                                       sh <= words[c];
            else if (bit_tick && state == SER_DATA && !last_bit) sh <= sh << 1;
        end

        assign ser_bits[c] = (state == SER_DATA) && sh[WORD_W-1];
    end
endmodule

// File: rtl/chan_out_port.sv
// Top of the channel output port. It joins the bit clock source, the word
// capture and parallel select, and the serial engine, then applies the
// output polarities and enables. All configuration inputs are assumed
// quasi-static.
module chan_out_port
    import chan_out_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int PAR_W  = 16,
    parameter int SEL_W  = 3,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osp_stb,
    input  logic [WORD_W-1:0] word_a,
    input  logic [WORD_W-1:0] word_b,
    input  logic              ser_en,
    input  logic              rdy_pol,
    input  logic              sck_pol,
    input  logic              fs_pol,
    input  logic              sck_ext_sel,
    input  logic [DIV_W-1:0]  sck_div,
    input  logic              sck_in,
    input  logic              par_en_pin,
    input  logic [SEL_W-1:0]  par_sel,
    output logic              ser_a,
    output logic              ser_b,
    output logic              ser_oe,
    output logic              sck_out,
    output logic              fs_out,
    output logic              rdy_out,
    output logic [PAR_W-1:0]  par_data,
    output logic              par_oe
);
    logic                       sck_raw;
    logic                       bit_tick;
    logic                       fs_raw;
    logic                       rdy_q;
    logic                       ser_oe_q;
    logic [NCH-1:0][WORD_W-1:0] lat_words;
    logic [NCH-1:0]             ser_bits;

    out_sck_gen #(.DIV_W(DIV_W)) u_sck (
        .clk      (clk),
        .rst_n    (rst_n),
        .use_ext  (sck_ext_sel),
        .div      (sck_div),
        .ext_sck  (sck_in),
        .sck_raw  (sck_raw),
        .bit_tick (bit_tick)
    );

    out_par_mux #(.WORD_W(WORD_W), .PAR_W(PAR_W), .SEL_W(SEL_W)) u_par (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (osp_stb),
        .word_a    (word_a),
        .word_b    (word_b),
        .sel       (par_sel),
        .lat_words (lat_words),
        .par_data  (par_data)
    );

    out_ser_shift #(.WORD_W(WORD_W)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .stb      (osp_stb),
        .words    (lat_words),
        .ser_bits (ser_bits),
        .fs_raw   (fs_raw)
    );

    // Ready pulse and serial enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q    <= 1'b0;
            ser_oe_q <= 1'b0;
        end else begin
            rdy_q    <= osp_stb;
            ser_oe_q <= ser_en;
        end
    end

    // Output polarity and enable mapping.
    assign rdy_out = rdy_q ^ rdy_pol;
    assign sck_out = sck_raw ^ sck_pol;
    assign fs_out  = fs_raw ^ fs_pol;
    assign ser_a   = ser_bits[0];
    assign ser_b   = ser_bits[1];
    assign ser_oe  = ser_oe_q;
    assign par_oe  = par_en_pin;
endmodule

// File: rtl/chan_out_port_chk.sv
// Property checker for chan_out_port, attached with bind below.
module chan_out_port_chk #(
    parameter int PAR_W = 16,
    parameter int SEL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             osp_stb,
    input logic             ser_en,
    input logic             rdy_pol,
    input logic             rdy_out,
    input logic             ser_oe,
    input logic [SEL_W-1:0] par_sel,
    input logic [PAR_W-1:0] par_data,
    input logic             bit_tick,
    input logic             sck_raw,
    input logic             fs_raw
);
    assert_rdy_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        osp_stb |=> (rdy_out != rdy_pol));
    assert_rdy_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !osp_stb |=> (rdy_out == rdy_pol));
    assert_ser_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ser_en |=> ser_oe);
    assert_ser_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en |=> !ser_oe);
    assert_par_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !osp_stb |=> (!$stable(par_sel) || $stable(par_data)));
    assert_tick_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sck_raw);
    assert_tick_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !sck_raw);
    assert_fs_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_raw && bit_tick) |=> !fs_raw);
endmodule

bind chan_out_port chan_out_port_chk #(.PAR_W(PAR_W), .SEL_W(SEL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .osp_stb  (osp_stb),
    .ser_en   (ser_en),
    .rdy_pol  (rdy_pol),
    .rdy_out  (rdy_out),
    .ser_oe   (ser_oe),
    .par_sel  (par_sel),
    .par_data (par_data),
    .bit_tick (bit_tick),
    .sck_raw  (sck_raw),
    .fs_raw   (fs_raw)
);

// File: tb/tb_chan_out_port.sv
module tb_chan_out_port;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        osp_stb = 0;
    logic [31:0] word_a = 0, word_b = 0;
    logic        ser_en = 0, rdy_pol = 0, sck_pol = 0, fs_pol = 0, sck_ext_sel = 0;
    logic [7:0]  sck_div = 1;
    logic        sck_in = 0, par_en_pin = 0;
    logic [2:0]  par_sel = 0;
    logic        ser_a, ser_b, ser_oe, sck_out, fs_out, rdy_out, par_oe;
    logic [15:0] par_data;

    chan_out_port dut (.*);

    always #10 clk = ~clk;

    int tests = 0, fails = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic [15:0] exp_mux(input [31:0] a, input [31:0] b, input [2:0] s);
        case (s)
            3'd0: exp_mux = a[31:16];
            3'd1: exp_mux = a[15:0];
            3'd2: exp_mux = b[31:16];
            3'd3: exp_mux = b[15:0];
            3'd4: exp_mux = {a[31:24], b[31:24]};
            3'd5: exp_mux = {a[23:16], b[23:16]};
            3'd6: exp_mux = {a[15:8], b[15:8]};
            default: exp_mux = {a[7:0], b[7:0]};
        endcase
    endfunction

    // Behavioural reference state, advanced on each rising edge.
    logic        m_rdy = 0, m_oe = 0;
    logic [31:0] m_a = 0, m_b = 0;
    logic [2:0]  hist = 0;
    int          since_rst = 0;
    always @(posedge clk) begin
        hist <= {hist[1:0], sck_in};
        if (!rst_n) begin
            m_rdy = 0; m_oe = 0; m_a = 0; m_b = 0; since_rst = 0;
        end else begin
            m_rdy = osp_stb; m_oe = ser_en; since_rst++;
            if (osp_stb) begin m_a = word_a; m_b = word_b; end
        end
    end

    // Serial receiver model state.
    logic [63:0] expq[$];
    bit          track = 0, hold_test = 0, hold_seen = 0, after_word = 0, s_prev = 0;
    int          dec_cnt = 0, frames = 0, cyc = 0, last_rise = -1, data_rises = 0;
    logic [31:0] ra, rb;

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        bit s, f;
        cyc++;
        if (rst_n) begin
            chk(rdy_out == (m_rdy ^ rdy_pol), "R6 rdy_out", rdy_out, m_rdy ^ rdy_pol);
            chk(ser_oe == m_oe, "R2 ser_oe", ser_oe, m_oe);
            chk(par_oe == par_en_pin, "R3 par_oe", par_oe, par_en_pin);
            chk(par_data == exp_mux(m_a, m_b, par_sel), "R4 par_data", par_data, exp_mux(m_a, m_b, par_sel));
            if (sck_ext_sel && since_rst >= 4)
                chk(sck_out == (hist[2] ^ sck_pol), "R8 sck_out delay", sck_out, hist[2] ^ sck_pol);
        end
        s = sck_out ^ sck_pol;
        f = fs_out ^ fs_pol;
        if (!rst_n) begin
            dec_cnt = 0; last_rise = -1; after_word = 0; s_prev = 0;
        end else if (s && !s_prev) begin
            if (!sck_ext_sel && last_rise >= 0 && track)
                chk(cyc - last_rise == 2 * (sck_div + 1), "R7 sck period", cyc - last_rise, 2 * (sck_div + 1));
            last_rise = cyc;
            if (after_word && hold_test) begin
                chk(f == 1'b1, "R11 held word frame sync without gap", f, 1);
                hold_seen = 1; hold_test = 0;
            end
            after_word = 0;
            if (dec_cnt > 0) begin
                if (track) chk(f == 1'b0, "R9 frame sync during data", f, 0);
                ra = {ra[30:0], ser_a}; rb = {rb[30:0], ser_b};
                dec_cnt--; data_rises++;
                if (dec_cnt == 0) begin
                    after_word = 1;
                    if (track) begin
                        frames++;
                        if (expq.size() == 0) chk(0, "R10 unexpected frame", {ra, rb}, 0);
                        else begin
                            logic [63:0] e;
                            e = expq.pop_front();
                            chk({ra, rb} == e, "R10 serial words", {ra, rb}, e);
                        end
                    end
                end
            end else if (f) begin
                dec_cnt = 32; data_rises = 0;
            end
        end
        s_prev = s;
    end

    // External bit clock generator: half period of three master cycles.
    bit ext_run = 0;
    initial forever begin
        @(posedge clk); #2;
        if (ext_run) begin
            repeat (2) @(posedge clk);
            #2 sck_in = ~sck_in;
        end else sck_in = 0;
    end

    task automatic step(input int n = 1);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic do_reset();
        rst_n = 0; track = 0; expq.delete(); frames = 0;
        step(3);
        rst_n = 1;
    endtask

    task automatic strobe(input [31:0] a, input [31:0] b);
        word_a = a; word_b = b; osp_stb = 1;
        if (track) expq.push_back({a, b});
        step(1);
        osp_stb = 0;
    endtask

    task automatic wait_frames(input int n);
        int guard = 0;
        while (frames < n && guard < 5000) begin step(1); guard++; end
        chk(frames >= n, "R10 frame count", frames, n);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        // R1: reset state.
        par_en_pin = 1; rdy_pol = 0;
        step(2);
        #5;
        chk(ser_oe == 0, "R1 ser_oe in reset", ser_oe, 0);
        chk(rdy_out == rdy_pol, "R1 rdy inactive in reset", rdy_out, rdy_pol);
        chk(par_data == 0, "R1 par_data in reset", par_data, 0);
        do_reset();
        #5;
        chk(ser_oe == 0, "R1 ser_oe after reset", ser_oe, 0);
        chk(par_data == 0, "R1 par_data after reset", par_data, 0);

        // R2, R3, R4, R5, R6: parallel path and ready, serial untracked.
        step(2);
        ser_en = 1; step(3); ser_en = 0; step(2);
        par_en_pin = 0; step(2); par_en_pin = 1;
        strobe(32'h1234_5678, 32'h9ABC_DEF0);
        for (int s = 0; s < 8; s++) begin par_sel = s[2:0]; step(2); end
        word_a = 32'hFFFF_0000; word_b = 32'h0F0F_0F0F; par_sel = 0;
        step(3);
        #5 chk(par_data == 16'h1234, "R5 unstrobed word change ignored", par_data, 16'h1234);
        step(1);
        rdy_pol = 1;
        strobe(32'hA5A5_3C3C, 32'h0123_4567);
        strobe(32'hDEAD_BEEF, 32'hCAFE_F00D);
        step(1);
        for (int s = 7; s >= 0; s--) begin par_sel = s[2:0]; step(1); end
        rdy_pol = 0;

        // R7, R9, R10: internal clock, two spaced words.
        ser_en = 1; sck_div = 1;
        do_reset(); track = 1;
        step(5);
        strobe(32'h8000_0001, 32'h7FFF_FFFE);
        wait_frames(1);
        step(7);
        strobe(32'hC3A5_5A3C, 32'h0000_FFFF);
        wait_frames(2);

        // R11: second word strobed mid-shift.
        sck_div = 0;
        do_reset(); track = 1;
        step(3);
        strobe(32'hF00D_1234, 32'h4321_D00F);
        while (data_rises < 10 || dec_cnt == 0) step(1);
        hold_test = 1; hold_seen = 0;
        strobe(32'h1357_9BDF, 32'h2468_ACE0);
        wait_frames(2);
        chk(hold_seen, "R11 held word observed", hold_seen, 1);

        // R7, R9: all polarities inverted, other divider.
        sck_div = 2; sck_pol = 1; fs_pol = 1; rdy_pol = 1;
        do_reset(); track = 1;
        step(4);
        strobe(32'h0F1E_2D3C, 32'hB4A5_9687);
        wait_frames(1);

        // R8: external clock source.
        sck_pol = 0; fs_pol = 0; rdy_pol = 0; sck_ext_sel = 1;
        do_reset(); track = 1;
        ext_run = 1;
        step(10);
        strobe(32'hAAAA_5555, 32'h5555_AAAA);
        wait_frames(1);
        strobe(32'h0000_0001, 32'h8000_0000);
        wait_frames(2);
        ext_run = 0;
        step(4);
        chk(expq.size() == 0, "R10 all words delivered", expq.size(), 0);
        finish_run();
    end
endmodule